// File: doc/BRIEF.md
# Peak-Current PWM Pulse Controller

This block generates the gate command for one switching cycle at a time in a peak-current-mode converter. An oscillator tick marks each cycle start. On that tick the block latches the cycle period in clock ticks and raises the gate. The gate then drops on the first of three events: the digitised switch current rises above the active limit, the on-time reaches the maximum duty fraction of the period, or enable falls. Once the gate has dropped it stays low until the next tick.

The active limit is the lower of two values. The first is a sawtooth that starts at a valley level at zero duty and climbs linearly to a flat level at a knee fraction of the period. The second is a soft-start ceiling that climbs slowly from a floor once enable is high. For a fixed number of clocks after each turn-on the current comparison is masked. This keeps the turn-on spike from cutting the pulse short. The sense input is a 10-bit code with 1 mV per step.

Top module: `pcm_pulse_ctrl`

## Requirements
- R1: While reset is held the gate is low. When a cycle-start tick is sampled with enable high, the gate is high from the next clock, and this holds even if the previous pulse had been cut.
- R2: Let e be the number of clocks since the last tick (e = 0 in the first clock after it). While e < BLANK_CYC the sense code is ignored, so a pulse whose sense code is high only during that window runs to the maximum-duty cut-off.
- R3: The gate is high only while e*100 < MAXD_PCT*P, where P is the period latched with the tick. With defaults this gives ceil(0.7*P) high clocks when nothing else ends the pulse.
- R4: The sawtooth limit in mV is VALLEY_MV + min(FLAT_MV-VALLEY_MV, floor((FLAT_MV-VALLEY_MV)*100*e/(KNEE_PCT*P))), so 440 rising to 500 with defaults. A sense code strictly greater than the effective limit at clock e, with e >= BLANK_CYC, makes the gate low from clock e+1. P must be at least 128.
- R5: The soft-start ceiling starts at SS_FLOOR_MV. It rises by 1 mV after every SS_STEP_CYC clocks with enable high and saturates at FLAT_MV. The effective limit is the lower of the ceiling and the sawtooth, so pulse widths under an unchanged sense waveform never shrink during the ramp.
- R6: With enable low the gate output is low in the same clock. The soft-start ceiling returns to SS_FLOOR_MV, and a tick sampled with enable low produces no pulse.
- R7: After the gate has dropped in a cycle it stays low until the next tick, even if the sense code falls back below the limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_start | input | 1 | One-clock tick marking a switching cycle start |
| cyc_period | input | CNT_W | Cycle length in clocks, sampled with the tick |
| enable | input | 1 | Run enable; low forces gate off and restarts soft-start |
| sense_mv | input | SENSE_W | Current-sense code, 1 mV per LSB |
| gate | output | 1 | Gate-on command |

## Verification
The checker watches state on every cycle. It confirms that a tick with enable high always starts a pulse and that the gate is never high past the maximum-duty point. It also confirms that the gate cannot drop inside the blanking window, that a cut pulse stays off until the next tick, that the sawtooth never falls within a cycle, and that the soft-start ceiling only rises while enabled. Only the bench scenarios can show the exact cut-off clock under rising sense ramps. They also show that the sawtooth holds the cut below the flat level early in the cycle, that pulse widths grow across the soft-start ramp, and that the gate drops in the same clock enable falls.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
    localparam int unsigned PCT_SCALE = 100;

    function automatic logic [15:0] min_u16(input logic [15:0] a, input logic [15:0] b);
        return (a < b) ? a : b;
    endfunction
endpackage

// File: rtl/pcm_cycle_ramp.sv
module pcm_cycle_ramp #(
    parameter int CNT_W     = 16,
    parameter int SENSE_W   = 10,
    parameter int VALLEY_MV = 440,
    parameter int FLAT_MV   = 500,
    parameter int KNEE_PCT  = 51,
    parameter int MAXD_PCT  = 70
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cyc_start,
    input  logic [CNT_W-1:0]   cyc_period,
    output logic [CNT_W-1:0]   cnt,
    output logic [CNT_W-1:0]   per,
    output logic [SENSE_W-1:0] saw_mv,
    output logic               on_expired
);
    localparam int RISE   = FLAT_MV - VALLEY_MV;
    localparam int STEP_W = $clog2(RISE + 1);
    localparam int PROD_W = CNT_W + 8;
    localparam logic [CNT_W-1:0]  CNT_MAX = {CNT_W{1'b1}};
    localparam logic [PROD_W-1:0] ACC_ADD = PROD_W'(RISE * pcm_pkg::PCT_SCALE);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  per;
        logic [PROD_W-1:0] acc;
        logic [STEP_W-1:0] step;
    } ramp_t;

    ramp_t st_q, st_d;
    logic [PROD_W-1:0] knee_lim;
    logic [PROD_W-1:0] acc_sum;
    logic [PROD_W-1:0] on_lim;

    always_comb begin
        st_d     = st_q;
        knee_lim = PROD_W'(st_q.per) * PROD_W'(KNEE_PCT);
        on_lim   = PROD_W'(st_q.per) * PROD_W'(MAXD_PCT);
        acc_sum  = st_q.acc + ACC_ADD;
        if (cyc_start) begin
            st_d.cnt  = '0;
            st_d.per  = cyc_period;
            st_d.acc  = '0;
            st_d.step = '0;
        end else begin
            if (st_q.cnt != CNT_MAX) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
            if (st_q.step != STEP_W'(RISE)) begin
                if (acc_sum >= knee_lim) begin
                    st_d.acc  = acc_sum - knee_lim;
                    st_d.step = st_q.step + 1'b1;
                end else begin
                    st_d.acc = acc_sum;
                end
            end
        end
        on_expired = !cyc_start &&
                     (PROD_W'(st_d.cnt) * PROD_W'(pcm_pkg::PCT_SCALE) >= on_lim);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt  <= '0;
            st_q.per  <= CNT_MAX;
            st_q.acc  <= '0;
            st_q.step <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt    = st_q.cnt;
    assign per    = st_q.per;
    assign saw_mv = SENSE_W'(VALLEY_MV) + SENSE_W'(st_q.step);
endmodule

// File: rtl/pcm_softstart.sv
module pcm_softstart #(
    parameter int SENSE_W     = 10,
    parameter int SS_FLOOR_MV = 100,
    parameter int SS_CEIL_MV  = 500,
    parameter int SS_STEP_CYC = 1000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    output logic [SENSE_W-1:0] ceil_mv
);
    localparam int PRE_W = (SS_STEP_CYC > 1) ? $clog2(SS_STEP_CYC) : 1;

    typedef struct packed {
        logic [PRE_W-1:0]   pre;
        logic [SENSE_W-1:0] lvl;
    } ss_t;

    ss_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (!enable) begin
            st_d.pre = '0;
            st_d.lvl = SENSE_W'(SS_FLOOR_MV);
        end else if (st_q.pre == PRE_W'(SS_STEP_CYC - 1)) begin
            st_d.pre = '0;
            if (st_q.lvl < SENSE_W'(SS_CEIL_MV)) begin
                st_d.lvl = st_q.lvl + 1'b1;
            end
        end else begin
            st_d.pre = st_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pre <= '0;
            st_q.lvl <= SENSE_W'(SS_FLOOR_MV);
        end else begin
            st_q <= st_d;
        end
    end

    assign ceil_mv = st_q.lvl;
endmodule

// File: rtl/pcm_gate_ctl.sv
module pcm_gate_ctl #(
    parameter int CNT_W     = 16,
    parameter int SENSE_W   = 10,
    parameter int BLANK_CYC = 36
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cyc_start,
    input  logic               enable,
    input  logic [CNT_W-1:0]   cnt,
    input  logic [SENSE_W-1:0] lim_mv,
    input  logic [SENSE_W-1:0] sense_mv,
    input  logic               on_expired,
    output logic               gate_q
);
    typedef struct packed {
        logic on;
    } gate_t;

    gate_t st_q, st_d;
    logic  blanked;
    logic  trip;

    always_comb begin
        st_d    = st_q;
        blanked = cnt < CNT_W'(BLANK_CYC);
        trip    = !blanked && (sense_mv > lim_mv);
        if (!enable) begin
            st_d.on = 1'b0;
        end else if (cyc_start) begin
            st_d.on = 1'b1;
        end else if (trip || on_expired) begin
            st_d.on = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.on <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gate_q = st_q.on;
endmodule

// File: rtl/pcm_pulse_ctrl.sv
module pcm_pulse_ctrl #(
    parameter int CNT_W       = 16,
    parameter int SENSE_W     = 10,
    parameter int VALLEY_MV   = 440,
    parameter int FLAT_MV     = 500,
    parameter int KNEE_PCT    = 51,
    parameter int MAXD_PCT    = 70,
    parameter int BLANK_CYC   = 36,
    parameter int SS_FLOOR_MV = 100,
    parameter int SS_STEP_CYC = 1000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cyc_start,
    input  logic [CNT_W-1:0]   cyc_period,
    input  logic               enable,
    input  logic [SENSE_W-1:0] sense_mv,
    output logic               gate
);
    logic [CNT_W-1:0]   cnt_w;
    logic [CNT_W-1:0]   per_w;
    logic [SENSE_W-1:0] saw_w;
    logic [SENSE_W-1:0] ss_w;
    logic [SENSE_W-1:0] lim_w;
    logic               expired_w;
    logic               gate_q_w;

    pcm_cycle_ramp #(
        .CNT_W(CNT_W), .SENSE_W(SENSE_W), .VALLEY_MV(VALLEY_MV),
        .FLAT_MV(FLAT_MV), .KNEE_PCT(KNEE_PCT), .MAXD_PCT(MAXD_PCT)
    ) ramp_i (
        .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cyc_period(cyc_period),
        .cnt(cnt_w), .per(per_w), .saw_mv(saw_w), .on_expired(expired_w)
    );

    pcm_softstart #(
        .SENSE_W(SENSE_W), .SS_FLOOR_MV(SS_FLOOR_MV),
        .SS_CEIL_MV(FLAT_MV), .SS_STEP_CYC(SS_STEP_CYC)
    ) ss_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .ceil_mv(ss_w)
    );

    assign lim_w = (saw_w < ss_w) ? saw_w : ss_w;

    pcm_gate_ctl #(
        .CNT_W(CNT_W), .SENSE_W(SENSE_W), .BLANK_CYC(BLANK_CYC)
    ) gate_i (
        .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .enable(enable),
        .cnt(cnt_w), .lim_mv(lim_w), .sense_mv(sense_mv),
        .on_expired(expired_w), .gate_q(gate_q_w)
    );

    assign gate = gate_q_w & enable;
endmodule

// File: rtl/pcm_pulse_ctrl_chk.sv
module pcm_pulse_ctrl_chk #(
    parameter int CNT_W       = 16,
    parameter int SENSE_W     = 10,
    parameter int VALLEY_MV   = 440,
    parameter int FLAT_MV     = 500,
    parameter int MAXD_PCT    = 70,
    parameter int BLANK_CYC   = 36,
    parameter int SS_FLOOR_MV = 100
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cyc_start,
    input logic               enable,
    input logic               gate_q,
    input logic [CNT_W-1:0]   cnt,
    input logic [CNT_W-1:0]   per,
    input logic [SENSE_W-1:0] saw_mv,
    input logic [SENSE_W-1:0] ss_mv
);
    localparam int PROD_W = CNT_W + 8;

    a_r1_tick_starts_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && enable) |=> gate_q);

    a_r2_no_cut_in_blank: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_q && enable && !cyc_start && (cnt < CNT_W'(BLANK_CYC))) |=> gate_q);

    a_r3_max_duty: assert property (@(posedge clk) disable iff (!rst_n)
        gate_q |-> (PROD_W'(cnt) * PROD_W'(100) < PROD_W'(per) * PROD_W'(MAXD_PCT)));

    a_r4_saw_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        (saw_mv >= SENSE_W'(VALLEY_MV)) && (saw_mv <= SENSE_W'(FLAT_MV)));

    a_r4_saw_rises: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_start |=> (saw_mv >= $past(saw_mv)));

    a_r5_ceiling_rises: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable)) |-> (ss_mv >= $past(ss_mv)));

    a_r6_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!gate_q && (ss_mv == SENSE_W'(SS_FLOOR_MV))));

    a_r7_stays_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_q && !cyc_start) |=> !gate_q);
endmodule

bind pcm_pulse_ctrl pcm_pulse_ctrl_chk #(
    .CNT_W(CNT_W), .SENSE_W(SENSE_W), .VALLEY_MV(VALLEY_MV), .FLAT_MV(FLAT_MV),
    .MAXD_PCT(MAXD_PCT), .BLANK_CYC(BLANK_CYC), .SS_FLOOR_MV(SS_FLOOR_MV)
) chk_i (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .enable(enable),
    .gate_q(gate_q_w), .cnt(cnt_w), .per(per_w), .saw_mv(saw_w), .ss_mv(ss_w)
);

// File: tb/pcm_pulse_ctrl_tb.sv
module pcm_pulse_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int BLANK      = 8;
    localparam int SS_STEP    = 16;
    localparam int SS_FLOOR   = 100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_start = 1'b0;
    logic [15:0] cyc_period = 16'd400;
    logic       enable = 1'b0;
    logic [9:0] sense_mv = '0;
    logic       gate;

    int checks = 0;
    int failures = 0;
    int mode = 0;       // 0 zero, 1 constant high, 2 ramp, 3 high in blank window, 4 spike at e=20
    int r_base = 0;
    int r_slope = 1;
    int tb_e = 0;

    // reference model state
    int m_e = 0, m_p = 65535, m_ss = SS_FLOOR, m_pre = 0;
    bit m_gate = 0;

    pcm_pulse_ctrl #(.BLANK_CYC(BLANK), .SS_FLOOR_MV(SS_FLOOR), .SS_STEP_CYC(SS_STEP)) dut_i (
        .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cyc_period(cyc_period),
        .enable(enable), .sense_mv(sense_mv), .gate(gate)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int sense_at(int e);
        int v;
        case (mode)
            1: v = 1023;
            2: v = r_base + r_slope * e;
            3: v = (e < BLANK) ? 1023 : 0;
            4: v = (e == 20) ? 1023 : 0;
            default: v = 0;
        endcase
        if (v > 1023) v = 1023;
        return v;
    endfunction

    function automatic int saw_at(int e, int p);
        int s;
        s = (6000 * e) / (51 * p);
        if (s > 60) s = 60;
        return 440 + s;
    endfunction

    // expected width when the ceiling is already at its top
    function automatic int exp_width(int p);
        for (int e = 0; e < 70000; e++) begin
            if (e * 100 >= 70 * p) return e;
            if (e >= BLANK && sense_at(e) > saw_at(e, p)) return e + 1;
        end
        return -1;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (cyc_start) tb_e <= 0;
        else tb_e <= tb_e + 1;
    end

    always @(negedge clk) sense_mv <= 10'(sense_at(tb_e));

    // behavioural reference model
    always @(posedge clk) begin
        int lim;
        bit trip;
        if (!rst_n) begin
            m_gate = 0; m_ss = SS_FLOOR; m_pre = 0; m_e = 0; m_p = 65535;
        end else begin
            lim = saw_at(m_e, m_p);
            if (m_ss < lim) lim = m_ss;
            trip = (m_e >= BLANK) && (int'(sense_mv) > lim);
            if (cyc_start) begin
                m_e = 0; m_p = int'(cyc_period); m_gate = enable;
            end else begin
                if (m_e < 65535) m_e = m_e + 1;
                if (trip || (m_e * 100 >= 70 * m_p)) m_gate = 0;
            end
            if (!enable) begin
                m_gate = 0; m_ss = SS_FLOOR; m_pre = 0;
            end else begin
                m_pre = m_pre + 1;
                if (m_pre == SS_STEP) begin
                    m_pre = 0;
                    if (m_ss < 500) m_ss = m_ss + 1;
                end
            end
        end
    end

    always @(negedge clk) begin
        #1;
        if (rst_n) chk("model compare R3 R4 R5 R7", int'(gate), int'(m_gate && enable));
    end

    task automatic run_cycle(input int p, output int w);
        w = 0;
        @(negedge clk); cyc_start = 1'b1; cyc_period = 16'(p);
        @(negedge clk); cyc_start = 1'b0;
        for (int i = 0; i < p; i++) begin
            #1;
            if (gate) w++;
            if (i < p - 1) @(negedge clk);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int w, w_prev, w_first;
        repeat (4) @(negedge clk);
        #1 chk("R1 reset gate low", int'(gate), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R6: tick while disabled
        run_cycle(200, w);
        chk("R6 no pulse while disabled", w, 0);

        enable = 1'b1; mode = 0;
        for (int k = 0; k < 17; k++) run_cycle(400, w);
        chk("R1 R3 max duty P=400", w, 280);
        run_cycle(200, w);
        chk("R3 max duty P=200", w, 140);
        run_cycle(128, w);
        chk("R3 max duty P=128", w, 90);

        mode = 1;
        run_cycle(400, w);
        chk("R2 blank then cut", w, BLANK + 1);
        mode = 3;
        run_cycle(400, w);
        chk("R2 spike inside blank ignored", w, 280);

        mode = 2; r_base = 380; r_slope = 1;
        run_cycle(400, w);
        chk("R4 ramp early cut", w, exp_width(400));
        chk("R4 cut below flat level", int'(w < 121), 1);
        r_base = 300;
        run_cycle(400, w);
        chk("R4 ramp late cut", w, exp_width(400));
        r_base = 200; r_slope = 2;
        run_cycle(300, w);
        chk("R4 steep ramp P=300", w, exp_width(300));

        mode = 4;
        run_cycle(400, w);
        chk("R7 stays off after trip", w, 21);

        // R6: drop enable mid-pulse
        mode = 0;
        @(negedge clk); cyc_start = 1'b1; cyc_period = 16'd400;
        @(negedge clk); cyc_start = 1'b0;
        repeat (29) @(negedge clk);
        #1 chk("R6 gate high before drop", int'(gate), 1);
        enable = 1'b0;
        #1 chk("R6 gate low same clock", int'(gate), 0);
        repeat (380) @(negedge clk);
        enable = 1'b1;

        // R5: widths grow over soft-start ramp
        mode = 2; r_base = 380; r_slope = 1;
        run_cycle(400, w_first);
        chk("R6 R5 ceiling back at floor", w_first, BLANK + 1);
        w_prev = w_first;
        for (int k = 0; k < 18; k++) begin
            run_cycle(400, w);
            chk("R5 width non-decreasing", int'(w >= w_prev), 1);
            w_prev = w;
        end
        chk("R5 ramp ends at sawtooth cut", w, exp_width(400));

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule